// File: doc/BRIEF.md
# Bit-Oriented Frame Serializer with Zero Insertion

This block turns a stream of bytes into the serial bit sequence of a bit-oriented synchronous link. Between frames it keeps the line busy with a programmable flag character. A frame holds, in order: an opening flag, one address character, any number of data bytes, two frame check bytes, and a closing flag. The address and flag characters come from two programmable character inputs. The data bytes arrive through a valid/ready byte port. The frame check value is supplied as a 16-bit input, because the CRC itself is computed elsewhere. One bit leaves per clock cycle in which the transmit enable is high, and every character is sent least significant bit first.

After five consecutive ones in the address, data or frame check fields, a zero is inserted into the line. Flags are never altered, and the run-of-ones counter is held at zero while a flag is being sent. An inserted zero uses one enable slot, and the character being shifted waits for that slot. If the next data byte is missing when it is needed in the middle of a frame, the block raises an underrun pulse and closes the frame with a flag at once, without sending frame check bytes.

The control is a six-state machine that advances only at character boundaries:

- `ST_IDLE` sends an idle flag.
- `ST_ADDR` sends the address character.
- `ST_DATA` sends a data byte.
- `ST_FCS_LO` and `ST_FCS_HI` send the two frame check bytes.
- `ST_CLOSE` sends the closing flag.

The transitions are as follows:

- From `ST_IDLE` or `ST_CLOSE`, the machine goes to `ST_ADDR` when `data_valid` is high at the boundary (the flag just sent serves as the opening flag). Otherwise it goes to `ST_IDLE`.
- From `ST_ADDR`, it goes to `ST_DATA` when a byte is offered. Otherwise it goes to `ST_CLOSE` with underrun.
- From `ST_DATA`, it goes to `ST_FCS_LO` after the byte marked last. It goes to `ST_DATA` when another byte is offered. Otherwise it goes to `ST_CLOSE` with underrun.
- `ST_FCS_LO` always goes to `ST_FCS_HI`.
- `ST_FCS_HI` always goes to `ST_CLOSE`.

Top module: `hdlc_tx_framer`

## Requirements
- R1: Reset is synchronous and active low. While in reset and just after it, `data_ready` and `underrun` are 0, and `tx_bit` shows bit 0 of `flag_char`, which is the first bit of an idle flag.
- R2: While `data_valid` stays low, the line carries `flag_char` repeatedly, bit 0 first, with no gaps.
- R3: A frame is sent in this order, each character bit 0 first: flag, `addr_char`, the data bytes in the order accepted, `fcs[7:0]`, `fcs[15:8]`, and a closing `flag_char`.
- R4: In the address, data and frame check fields, a 0 is inserted after every fifth consecutive 1. Runs are counted across field boundaries. Any 0 sent, including an inserted one, restarts the count.
- R5: No zero is inserted while a flag is sent, and ones in a flag do not count toward the run that follows it.
- R6: An inserted zero occupies one enable slot, so the next payload bit is delayed by one enable.
- R7: `data_ready` is high for a single cycle, only together with `bit_en` and `data_valid`, and the byte on `data_in` is consumed in that cycle. A byte taken with `data_last`=1 is the final data byte of its frame.
- R8: If no byte is offered when the address or a non-final data byte ends, `underrun` pulses for one cycle. The closing flag then follows directly, with no frame check bytes.
- R9: `tx_bit` changes only after a cycle in which `bit_en` was high.
- R10: A frame starts at the first flag boundary at which `data_valid` is high. Frames may follow each other, sharing one flag as closing and opening flag.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bit_en | input | 1 | Transmit bit enable, one line bit per high cycle |
| flag_char | input | 8 | Flag character (second sync register) |
| addr_char | input | 8 | Address character (first sync register) |
| data_in | input | 8 | Data byte offered |
| data_valid | input | 1 | `data_in` is valid; high at a flag boundary requests a frame |
| data_last | input | 1 | Offered byte is the last data byte of the frame |
| data_ready | output | 1 | Byte on `data_in` consumed this cycle |
| fcs | input | 16 | Frame check value, low byte sent first |
| tx_bit | output | 1 | Serial line output |
| underrun | output | 1 | One-cycle pulse: data missing in mid-frame |

## Verification
The assertions rely on a few conditions on the inputs:
- `flag_char` changes only during reset.
- An offered byte, with its `data_last`, stays put until it is consumed.
- `fcs` is stable from acceptance of the last byte until its low byte is loaded.

The run-of-ones property also relies on the machine's flag indication, to tell flag bits from field bits. The stimulus changes characters and the frame check value only while reset is held. It advances the offered byte only in the cycle after a consumption, and it cuts the supply only to provoke an underrun on purpose.

// File: rtl/hdlc_tx_pkg.sv
package hdlc_tx_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADDR,
        ST_DATA,
        ST_FCS_LO,
        ST_FCS_HI,
        ST_CLOSE
    } tx_state_e;
endpackage

// File: rtl/hdlc_tx_shifter.sv
module hdlc_tx_shifter #(
    parameter int CHAR_W  = 8,
    parameter int RUN_MAX = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bit_en,
    input  logic              in_flag,
    input  logic [CHAR_W-1:0] load_val,
    output logic              tx_bit,
    output logic              byte_end
);
    localparam int CNT_W = $clog2(CHAR_W);
    localparam int RUN_W = $clog2(RUN_MAX + 1);
    localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(CHAR_W - 1);
    localparam logic [RUN_W-1:0] RUN_LIM  = RUN_W'(RUN_MAX);

    logic [CHAR_W-1:0] sh_q;
    logic [CNT_W-1:0]  cnt_q;
    logic [RUN_W-1:0]  run_q;
    logic              stuff_now;

    // a full run of ones forces the next slot to an inserted zero
    assign stuff_now = (run_q == RUN_LIM);
    assign tx_bit    = stuff_now ? 1'b0 : sh_q[0];
    assign byte_end  = bit_en && !stuff_now && (cnt_q == LAST_BIT);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sh_q  <= load_val;
            cnt_q <= '0;
            run_q <= '0;
        end else if (bit_en) begin
            if (stuff_now) begin
                run_q <= '0;
            end else begin
                run_q <= (in_flag || !sh_q[0]) ? '0 : run_q + 1'b1;
                if (cnt_q == LAST_BIT) begin
                    sh_q  <= load_val;
                    cnt_q <= '0;
                end else begin
                    sh_q  <= sh_q >> 1;
                    cnt_q <= cnt_q + 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/hdlc_tx_framer.sv
module hdlc_tx_framer #(
    parameter int CHAR_W  = 8,
    parameter int RUN_MAX = 5
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                bit_en,
    input  logic [CHAR_W-1:0]   flag_char,
    input  logic [CHAR_W-1:0]   addr_char,
    input  logic [CHAR_W-1:0]   data_in,
    input  logic                data_valid,
    input  logic                data_last,
    output logic                data_ready,
    input  logic [2*CHAR_W-1:0] fcs,
    output logic                tx_bit,
    output logic                underrun
);
    import hdlc_tx_pkg::*;

    tx_state_e         state_q, state_d;
    logic              byte_end;
    logic              flag_field;
    logic              last_q;
    logic              underrun_evt;
    logic [CHAR_W-1:0] fcs_hi_q;
    logic [CHAR_W-1:0] load_val;

    assign flag_field = (state_q == ST_IDLE) || (state_q == ST_CLOSE);

    // state register: moves only at character boundaries
    always_ff @(posedge clk) begin
        if (!rst_n)
            state_q <= ST_IDLE;
        else if (byte_end)
            state_q <= state_d;
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE, ST_CLOSE: state_d = data_valid ? ST_ADDR : ST_IDLE;
            ST_ADDR:           state_d = data_valid ? ST_DATA : ST_CLOSE;
            ST_DATA:           state_d = last_q ? ST_FCS_LO
                                       : (data_valid ? ST_DATA : ST_CLOSE);
            ST_FCS_LO:         state_d = ST_FCS_HI;
            ST_FCS_HI:         state_d = ST_CLOSE;
            default:           state_d = ST_IDLE;
        endcase
    end

    // outputs and shift register source
    always_comb begin
        data_ready   = byte_end && (state_d == ST_DATA);
        underrun_evt = byte_end && !data_valid &&
                       ((state_q == ST_ADDR) || ((state_q == ST_DATA) && !last_q));
        load_val     = flag_char;
        if (rst_n) begin
            unique case (state_d)
                ST_IDLE, ST_CLOSE: load_val = flag_char;
                ST_ADDR:           load_val = addr_char;
                ST_DATA:           load_val = data_in;
                ST_FCS_LO:         load_val = fcs[CHAR_W-1:0];
                ST_FCS_HI:         load_val = fcs_hi_q;
                default:           load_val = flag_char;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            last_q   <= 1'b0;
            fcs_hi_q <= '0;
            underrun <= 1'b0;
        end else begin
            underrun <= underrun_evt;
            if (data_ready)
                last_q <= data_last;
            if (byte_end && (state_d == ST_FCS_LO))
                fcs_hi_q <= fcs[2*CHAR_W-1:CHAR_W];
        end
    end

    hdlc_tx_shifter #(
        .CHAR_W  (CHAR_W),
        .RUN_MAX (RUN_MAX)
    ) u_shift (
        .clk      (clk),
        .rst_n    (rst_n),
        .bit_en   (bit_en),
        .in_flag  (flag_field),
        .load_val (load_val),
        .tx_bit   (tx_bit),
        .byte_end (byte_end)
    );
endmodule

// File: rtl/hdlc_tx_framer_chk.sv
module hdlc_tx_framer_chk (
    input logic clk,
    input logic rst_n,
    input logic bit_en,
    input logic tx_bit,
    input logic data_ready,
    input logic data_valid,
    input logic underrun,
    input logic in_flag
);
    logic [2:0] ones_seen_q;

    // independent count of line ones outside flag characters
    always_ff @(posedge clk) begin
        if (!rst_n)
            ones_seen_q <= '0;
        else if (bit_en)
            ones_seen_q <= (tx_bit && !in_flag) ? ones_seen_q + 1'b1 : 3'd0;
    end

    AST_RUN_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
        ones_seen_q <= 3'd5);                                   // R4
    AST_READY_QUALIFIED: assert property (@(posedge clk) disable iff (!rst_n)
        data_ready |-> (bit_en && data_valid));                 // R7
    AST_READY_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        data_ready |=> !data_ready);                            // R7
    AST_UNDERRUN_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        underrun |=> !underrun);                                // R8
    AST_LINE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !bit_en |=> $stable(tx_bit));                           // R9
endmodule

bind hdlc_tx_framer hdlc_tx_framer_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .bit_en     (bit_en),
    .tx_bit     (tx_bit),
    .data_ready (data_ready),
    .data_valid (data_valid),
    .underrun   (underrun),
    .in_flag    (flag_field)
);

// File: tb/sim_hdlc_tx_framer.sv
module sim_hdlc_tx_framer;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bit_en = 1'b0;
    logic [7:0]  flag_char = 8'h7E;
    logic [7:0]  addr_char = 8'h00;
    logic [7:0]  data_in = 8'h00;
    logic        data_valid = 1'b0;
    logic        data_last = 1'b0;
    logic        data_ready;
    logic [15:0] fcs = 16'h0000;
    logic        tx_bit;
    logic        underrun;

    always #10 clk = ~clk;   // 50 MHz

    hdlc_tx_framer u0 (
        .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .flag_char(flag_char),
        .addr_char(addr_char), .data_in(data_in), .data_valid(data_valid),
        .data_last(data_last), .data_ready(data_ready), .fcs(fcs),
        .tx_bit(tx_bit), .underrun(underrun)
    );

    int n_chk = 0, n_bad = 0;
    bit exp_q[$];
    bit got_q[$];
    int ones_m;
    logic [7:0] pay [0:63];
    bit  lastm [0:63];
    int  idx, stop_at, start_at, issued, en_div, phase, acc_n, und_n, r9_bad;
    bit  run = 0, pend, prev_en, prev_tx, prev_ok, done = 0;

    task automatic chk(input bit ok, input string tag, input int act, input int expv);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, expv);
        end
    endtask

    // ---------------- expected stream model ----------------
    task automatic push_flag(input logic [7:0] f);
        for (int i = 0; i < 8; i++) exp_q.push_back(f[i]);
        ones_m = 0;
    endtask

    task automatic push_field(input logic [7:0] v);
        for (int i = 0; i < 8; i++) begin
            exp_q.push_back(v[i]);
            ones_m = v[i] ? ones_m + 1 : 0;
            if (ones_m == 5) begin
                exp_q.push_back(1'b0);
                ones_m = 0;
            end
        end
    endtask

    // ---------------- line capture and byte source ----------------
    always @(negedge clk) begin
        if (run) begin
            if (pend) idx++;
            data_valid = (issued >= start_at) && (idx < stop_at);
            data_in    = pay[idx[5:0]];
            data_last  = lastm[idx[5:0]];
            if (prev_ok && !prev_en && tx_bit !== prev_tx) r9_bad++;
            phase++;
            bit_en = (phase % en_div) == 0;
            #1;
            if (bit_en) begin
                got_q.push_back(tx_bit);
                issued++;
            end
            pend = data_ready && data_valid;
            if (pend) acc_n++;
            if (underrun) und_n++;
            prev_en = bit_en;
            prev_tx = tx_bit;
            prev_ok = 1'b1;
        end else begin
            bit_en     = 1'b0;
            data_valid = 1'b0;
        end
    end

    task automatic begin_case(input logic [7:0] f, input logic [7:0] a,
                              input logic [15:0] c, input int st_at,
                              input int sp_at, input int div);
        @(posedge clk);
        run = 0;
        rst_n = 0;
        flag_char = f; addr_char = a; fcs = c;
        start_at = st_at; stop_at = sp_at; en_div = div;
        idx = 0; issued = 0; phase = 0; acc_n = 0; und_n = 0; r9_bad = 0;
        pend = 0; prev_ok = 0; prev_en = 0; prev_tx = 0;
        exp_q.delete(); got_q.delete(); ones_m = 0;
        repeat (3) @(posedge clk);
        #2;
        chk(tx_bit === f[0] && data_ready === 1'b0 && underrun === 1'b0,
            "R1 reset line/outputs", int'(tx_bit), int'(f[0]));
        rst_n = 1;
        run = 1;
    endtask

    task automatic finish_case(input string tag, input int exp_acc, input int exp_und);
        int guard = 0;
        int bad_at = -1;
        while (got_q.size() < exp_q.size() && guard < 6000) begin
            @(posedge clk);
            guard++;
        end
        @(posedge clk);
        run = 0;
        for (int i = 0; i < exp_q.size(); i++)
            if (bad_at < 0 && (i >= got_q.size() || got_q[i] !== exp_q[i])) bad_at = i;
        if (bad_at >= 0)
            chk(1'b0, $sformatf("%s stream bit %0d", tag, bad_at),
                (bad_at < got_q.size()) ? int'(got_q[bad_at]) : -1, int'(exp_q[bad_at]));
        else
            chk(1'b1, tag, 0, 0);
        chk(acc_n == exp_acc, {"R7 bytes consumed ", tag}, acc_n, exp_acc);
        chk(und_n == exp_und, {"R8 underrun pulses ", tag}, und_n, exp_und);
        chk(r9_bad == 0, {"R9 line moved without enable ", tag}, r9_bad, 0);
    endtask

    initial begin
        // R2/R5: idle flags of all ones, never stuffed
        begin_case(8'hFF, 8'h00, 16'h0000, 1 << 30, 0, 1);
        for (int k = 0; k < 4; k++) push_flag(8'hFF);
        finish_case("R2 R5 idle ones flag", 0, 0);

        // R5: ones of the flag do not start the address run
        for (int i = 0; i < 64; i++) begin pay[i] = 8'h00; lastm[i] = 1'b0; end
        pay[0] = 8'h3F; lastm[0] = 1'b1;
        begin_case(8'hFF, 8'h1F, 16'hF0F8, 0, 1, 2);
        push_flag(8'hFF); push_field(8'h1F); push_field(8'h3F);
        push_field(8'hF8); push_field(8'hF0); push_flag(8'hFF);
        push_flag(8'hFF); push_flag(8'hFF);
        finish_case("R5 R4 flag run isolation", 1, 0);

        // R3/R4/R6: sweep of every single data byte value
        for (int v = 0; v < 256; v++) begin
            logic [7:0] a, d;
            logic [15:0] c;
            a = 8'(v) ^ 8'hA5;
            d = 8'(v);
            c = {8'(v) ^ 8'h5A, ~8'(v)};
            pay[0] = d; lastm[0] = 1'b1;
            begin_case(8'h7E, a, c, 0, 1, (v % 3) + 1);
            push_flag(8'h7E); push_field(a); push_field(d);
            push_field(c[7:0]); push_field(c[15:8]);
            push_flag(8'h7E); push_flag(8'h7E); push_flag(8'h7E);
            finish_case("R3 R4 R6 byte sweep", 1, 0);
        end

        // R4/R6: long runs of ones across field boundaries
        for (int i = 0; i < 12; i++) begin pay[i] = 8'hFF; lastm[i] = (i == 11); end
        begin_case(8'h7E, 8'hFF, 16'hFFFF, 0, 12, 1);
        push_flag(8'h7E); push_field(8'hFF);
        for (int i = 0; i < 12; i++) push_field(8'hFF);
        push_field(8'hFF); push_field(8'hFF);
        push_flag(8'h7E); push_flag(8'h7E);
        finish_case("R4 R6 all ones frame", 12, 0);

        // R8: byte supply stops after three bytes
        pay[0] = 8'h81; pay[1] = 8'hF8; pay[2] = 8'h1F;
        for (int i = 0; i < 4; i++) lastm[i] = 1'b0;
        begin_case(8'h7E, 8'h3C, 16'h1234, 0, 3, 2);
        push_flag(8'h7E); push_field(8'h3C);
        push_field(8'h81); push_field(8'hF8); push_field(8'h1F);
        push_flag(8'h7E); push_flag(8'h7E); push_flag(8'h7E);
        finish_case("R8 underrun close", 3, 1);

        // R10: back-to-back frames sharing one flag
        pay[0] = 8'h11; lastm[0] = 1'b0;
        pay[1] = 8'hEE; lastm[1] = 1'b1;
        pay[2] = 8'h7C; lastm[2] = 1'b1;
        begin_case(8'h7E, 8'hC3, 16'hBEEF, 0, 3, 1);
        push_flag(8'h7E); push_field(8'hC3); push_field(8'h11); push_field(8'hEE);
        push_field(8'hEF); push_field(8'hBE); push_flag(8'h7E);
        push_field(8'hC3); push_field(8'h7C); push_field(8'hEF); push_field(8'hBE);
        push_flag(8'h7E); push_flag(8'h7E);
        finish_case("R10 back to back", 3, 0);

        // R10/R2: request raised mid-flag waits for the flag boundary
        pay[0] = 8'h5A; lastm[0] = 1'b1;
        begin_case(8'h7E, 8'h96, 16'h0F0F, 20, 1, 2);
        push_flag(8'h7E); push_flag(8'h7E); push_flag(8'h7E);
        push_field(8'h96); push_field(8'h5A); push_field(8'h0F); push_field(8'h0F);
        push_flag(8'h7E); push_flag(8'h7E);
        finish_case("R10 late start", 1, 0);

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        #(20 * 190000);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog expired actual=0 expected=1");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end
endmodule